// File: doc/BRIEF.md
# Bridge Configuration Space Decoder

This block is the register front end of one switch-port bridge function. The function owns a 4 KB configuration space. The space is split into three regions: a standard header region at byte offsets 0x000–0x0FF, an extended capability region at 0x100–0x3FF, and a vendor port-specific region at 0x400–0xFFF. Two request paths share the block. The primary configuration path carries normal host accesses. The side-band path stands in for a management or boot-time loader master. Both paths use a 10-bit dword address, four byte enables and a 32-bit write word. Reads return one cycle later on a single response port.

The `port_ds` input gives the port mode: 1 for downstream, 0 for upstream. In upstream mode the slot registers are hidden from the primary path. The side-band path reaches every register in both modes, except the indirect window. That window is an address/data pair in the standard region that lets legacy software reach the extended region. The capability chain is kept through next-pointer fields. Their default values depend on the port mode until the side-band path programs them.

Top module: `bridge_cfg_space`

## Requirements
- R1: An accepted read drives `rsp_vld` high in the next cycle, with `rsp_data` set and `rsp_sb` high when the side-band path made the read. A write gives no response. After reset `rsp_vld` is 0.
- R2: Any offset that is not implemented reads as 0. This covers all three regions, and the vendor region beyond the last of `VND_WORDS` dwords at 0x400.
- R3: A write to a reserved offset completes and changes no register.
- R4: The read/write registers update only the bytes whose byte enable is set (bit i covers data bits 8i+7:8i). They are: scratch at 0x00C, extended-capability data at 0x144, and the vendor dwords at 0x400 + 4·k.
- R5: The slot capability register at 0x054 and the slot control register at 0x058 are seen by the primary path only when `port_ds`=1. In upstream mode, primary reads of them return 0 and primary writes to them are dropped. The stored value is kept.
- R6: The read-only registers return fixed values. Offset 0x000 returns `ID_VALUE`. Offset 0x034 returns 0x40. The header at 0x040 returns 0x10 in bits 7:0, its next pointer in bits 15:8, 2 in bits 19:16, the port type in bits 23:20 (6 when downstream, 5 when upstream) and 0 in bits 31:24.
- R7: Only bits 11:2 of the window address register at 0x0F8 are writable; the other bits read 0. A primary access to 0x0FC is carried out at the byte offset held in 0x0F8 when that offset is at or above 0x100. Otherwise the access behaves as reserved.
- R8: Side-band accesses to 0x0F8 and 0x0FC behave as reserved: reads return 0 and writes are dropped.
- R9: The side-band path reads and writes the slot registers in either port mode. It reaches all other implemented registers with the same results as the primary path.
- R10: The extended headers at 0x100 and 0x140 read 1 in bits 15:0 and 0xB in bits 15:0 respectively. Both read 1 in bits 19:16 and carry their next pointer in bits 31:20. Until programmed, the next pointer at 0x100 reads `EXT0_DS_NEXT` when downstream and 0 when upstream. The next pointers at 0x140 and 0x040 read 0.
- R11: Only side-band writes change a next pointer. Byte enables apply: bit 1 for 0x040, bits 2–3 for 0x100 and 0x140. Once written, the value is held whatever the port mode. Primary writes to the headers change nothing.
- R12: `sb_rdy` is the inverse of `pri_req`. When both paths request in the same cycle, only the primary access is performed and the side-band request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_ds | input | 1 | Port mode: 1 downstream, 0 upstream |
| pri_req | input | 1 | Primary access request |
| pri_we | input | 1 | Primary write (1) or read (0) |
| pri_addr | input | 10 | Primary dword address |
| pri_be | input | 4 | Primary byte enables |
| pri_wdata | input | 32 | Primary write data |
| sb_req | input | 1 | Side-band access request |
| sb_we | input | 1 | Side-band write (1) or read (0) |
| sb_addr | input | 10 | Side-band dword address |
| sb_be | input | 4 | Side-band byte enables |
| sb_wdata | input | 32 | Side-band write data |
| sb_rdy | output | 1 | Side-band request accepted this cycle |
| rsp_vld | output | 1 | Read data valid |
| rsp_sb | output | 1 | Response belongs to the side-band path |
| rsp_data | output | 32 | Read data |

## Verification
The bench builds the block with `VND_WORDS`=3. With three vendor dwords, the vendor index field can still address a fourth dword at 0x40C, so the bench can check that this slot decodes as reserved. `ID_VALUE` is set to a value different from the default, so the identity read shows the parameter is passed through. `EXT0_DS_NEXT` keeps 0x140, so the default chain in downstream mode points at the second extended header. Switching `port_ds` during the run covers the hidden slot registers, the mode-dependent default links, and links that stay fixed once programmed.

// File: rtl/brcfg_pkg.sv
package brcfg_pkg;
  localparam int CFG_AW = 10;
  localparam int CFG_DW = 32;
  localparam int CFG_BW = CFG_DW / 8;

  typedef logic [CFG_AW-1:0] dwaddr_t;
  typedef logic [CFG_DW-1:0] word_t;
  typedef logic [CFG_BW-1:0] be_t;

  // dword addresses; the header chain and window positions are fixed by the map
  localparam dwaddr_t A_ID      = 10'h000;
  localparam dwaddr_t A_SCRATCH = 10'h003;
  localparam dwaddr_t A_CAPPTR  = 10'h00D;
  localparam dwaddr_t A_PCIE    = 10'h010;
  localparam dwaddr_t A_SLOTCAP = 10'h015;
  localparam dwaddr_t A_SLOTCTL = 10'h016;
  localparam dwaddr_t A_WADDR   = 10'h03E;
  localparam dwaddr_t A_WDATA   = 10'h03F;
  localparam dwaddr_t A_EXT0    = 10'h040;
  localparam dwaddr_t A_EXT1    = 10'h050;
  localparam dwaddr_t A_EXT1R   = 10'h051;
  localparam dwaddr_t A_VND     = 10'h100;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_SCRATCH, SEL_CAPPTR, SEL_PCIE, SEL_SLOTCAP,
    SEL_SLOTCTL, SEL_WADDR, SEL_WDATA, SEL_EXT0, SEL_EXT1, SEL_EXT1R, SEL_VND
  } sel_e;

  function automatic word_t be_merge(word_t old_w, word_t new_w, be_t be);
    word_t r;
    r = old_w;
    for (int i = 0; i < CFG_BW; i++) begin
      if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/brcfg_arb.sv
module brcfg_arb
  import brcfg_pkg::*;
(
  input  logic    pri_req,
  input  logic    pri_we,
  input  dwaddr_t pri_addr,
  input  be_t     pri_be,
  input  word_t   pri_wdata,
  input  logic    sb_req,
  input  logic    sb_we,
  input  dwaddr_t sb_addr,
  input  be_t     sb_be,
  input  word_t   sb_wdata,
  output logic    sb_rdy,
  output logic    acc_vld,
  output logic    acc_we,
  output logic    acc_sb,
  output dwaddr_t acc_addr,
  output be_t     acc_be,
  output word_t   acc_wdata
);
  // primary path has fixed priority; side-band waits while it is busy
  always_comb begin
    sb_rdy  = ~pri_req;
    acc_vld = pri_req | sb_req;
    acc_sb  = sb_req & ~pri_req;
    if (pri_req) begin
      acc_we    = pri_we;
      acc_addr  = pri_addr;
      acc_be    = pri_be;
      acc_wdata = pri_wdata;
    end else begin
      acc_we    = sb_we;
      acc_addr  = sb_addr;
      acc_be    = sb_be;
      acc_wdata = sb_wdata;
    end
  end
endmodule

// File: rtl/brcfg_decode.sv
module brcfg_decode
  import brcfg_pkg::*;
#(
  parameter int VND_WORDS = 4,
  parameter int VIDX_W    = 2
) (
  input  dwaddr_t           addr,
  input  logic              via_sb,
  input  logic              fwd,
  input  logic              port_ds,
  output sel_e              sel,
  output logic [VIDX_W-1:0] vidx
);
  localparam dwaddr_t VND_LIM = dwaddr_t'(VND_WORDS);

  dwaddr_t voff;

  always_comb begin
    voff = addr - A_VND;
    vidx = voff[VIDX_W-1:0];
    sel  = SEL_NONE;
    case (addr)
      A_ID:      sel = SEL_ID;
      A_SCRATCH: sel = SEL_SCRATCH;
      A_CAPPTR:  sel = SEL_CAPPTR;
      A_PCIE:    sel = SEL_PCIE;
      A_SLOTCAP: if (port_ds || via_sb) sel = SEL_SLOTCAP;
      A_SLOTCTL: if (port_ds || via_sb) sel = SEL_SLOTCTL;
      A_WADDR:   if (!via_sb) sel = SEL_WADDR;
      A_WDATA:   if (!via_sb) sel = SEL_WDATA;
      A_EXT0:    sel = SEL_EXT0;
      A_EXT1:    sel = SEL_EXT1;
      A_EXT1R:   sel = SEL_EXT1R;
      default:   if (addr >= A_VND && voff < VND_LIM) sel = SEL_VND;
    endcase
    // forwarded window accesses reach only the extended and vendor regions
    if (fwd && addr < A_EXT0) sel = SEL_NONE;
  end
endmodule

// File: rtl/brcfg_regs.sv
module brcfg_regs
  import brcfg_pkg::*;
#(
  parameter word_t       ID_VALUE     = 32'h0000_0000,
  parameter int          VND_WORDS    = 4,
  parameter int          VIDX_W       = 2,
  parameter logic [11:0] EXT0_DS_NEXT = 12'h140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_ds,
  input  logic              acc_vld,
  input  logic              acc_we,
  input  logic              acc_sb,
  input  be_t               acc_be,
  input  word_t             acc_wdata,
  input  sel_e              sel,
  input  logic [VIDX_W-1:0] vidx,
  output word_t             rdata,
  output dwaddr_t           win_dw
);
  logic        wr;
  word_t       merged;
  word_t       scratch_q, scratch_d, slotcap_q, slotcap_d, slotctl_q, slotctl_d;
  word_t       ext1r_q, ext1r_d;
  dwaddr_t     waddr_q, waddr_d;
  logic [7:0]  pnx_q, pnx_d;
  logic [11:0] e0nx_q, e0nx_d, e1nx_q, e1nx_d;
  logic        pprog_q, pprog_d, e0prog_q, e0prog_d, e1prog_q, e1prog_d;
  logic [7:0]  pnx_eff;
  logic [11:0] e0nx_eff, e1nx_eff;
  word_t       vnd_rd [VND_WORDS];

  assign wr     = acc_vld & acc_we;
  assign win_dw = waddr_q;

  // next pointers follow the mode-dependent default until programmed
  assign pnx_eff  = pprog_q  ? pnx_q  : 8'h00;
  assign e0nx_eff = e0prog_q ? e0nx_q : (port_ds ? EXT0_DS_NEXT : 12'h000);
  assign e1nx_eff = e1prog_q ? e1nx_q : 12'h000;

  always_comb begin
    case (sel)
      SEL_ID:      rdata = ID_VALUE;
      SEL_SCRATCH: rdata = scratch_q;
      SEL_CAPPTR:  rdata = 32'h0000_0040;
      SEL_PCIE:    rdata = {8'h00, (port_ds ? 4'h6 : 4'h5), 4'h2, pnx_eff, 8'h10};
      SEL_SLOTCAP: rdata = slotcap_q;
      SEL_SLOTCTL: rdata = slotctl_q;
      SEL_WADDR:   rdata = {20'h0, waddr_q, 2'b00};
      SEL_EXT0:    rdata = {e0nx_eff, 4'h1, 16'h0001};
      SEL_EXT1:    rdata = {e1nx_eff, 4'h1, 16'h000B};
      SEL_EXT1R:   rdata = ext1r_q;
      SEL_VND:     rdata = vnd_rd[vidx];
      default:     rdata = '0;
    endcase
  end

  assign merged = be_merge(rdata, acc_wdata, acc_be);

  always_comb begin
    scratch_d = scratch_q;
    slotcap_d = slotcap_q;
    slotctl_d = slotctl_q;
    ext1r_d   = ext1r_q;
    waddr_d   = waddr_q;
    pnx_d     = pnx_q;
    pprog_d   = pprog_q;
    e0nx_d    = e0nx_q;
    e0prog_d  = e0prog_q;
    e1nx_d    = e1nx_q;
    e1prog_d  = e1prog_q;
    case (sel)
      SEL_SCRATCH: scratch_d = merged;
      SEL_SLOTCAP: slotcap_d = merged;
      SEL_SLOTCTL: slotctl_d = merged;
      SEL_EXT1R:   ext1r_d   = merged;
      SEL_WADDR:   waddr_d   = merged[11:2];
      SEL_PCIE: if (acc_sb && acc_be[1]) begin
        pnx_d   = merged[15:8];
        pprog_d = 1'b1;
      end
      SEL_EXT0: if (acc_sb && (|acc_be[3:2])) begin
        e0nx_d   = merged[31:20];
        e0prog_d = 1'b1;
      end
      SEL_EXT1: if (acc_sb && (|acc_be[3:2])) begin
        e1nx_d   = merged[31:20];
        e1prog_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      slotcap_q <= '0;
      slotctl_q <= '0;
      ext1r_q   <= '0;
      waddr_q   <= '0;
      pnx_q     <= '0;
      pprog_q   <= 1'b0;
      e0nx_q    <= '0;
      e0prog_q  <= 1'b0;
      e1nx_q    <= '0;
      e1prog_q  <= 1'b0;
    end else if (wr) begin
      scratch_q <= scratch_d;
      slotcap_q <= slotcap_d;
      slotctl_q <= slotctl_d;
      ext1r_q   <= ext1r_d;
      waddr_q   <= waddr_d;
      pnx_q     <= pnx_d;
      pprog_q   <= pprog_d;
      e0nx_q    <= e0nx_d;
      e0prog_q  <= e0prog_d;
      e1nx_q    <= e1nx_d;
      e1prog_q  <= e1prog_d;
    end
  end

  for (genvar gi = 0; gi < VND_WORDS; gi++) begin : g_vnd
    logic  en;
    word_t q;
    assign en = wr && (sel == SEL_VND) && (vidx == VIDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= merged;
    end
    assign vnd_rd[gi] = q;
  end

  // R11: no link field moves unless the side-band path writes that header
  p_pri_no_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_sb) |=> ($stable(pnx_q) && $stable(e0nx_q) && $stable(e1nx_q)
                              && $stable(e0prog_q)));
  p_e0_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && acc_sb && sel == SEL_EXT0) |=> ($stable(e0nx_q) && $stable(e0prog_q)));
endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space
  import brcfg_pkg::*;
#(
  parameter logic [31:0] ID_VALUE     = 32'h1D7A_8086,
  parameter int          VND_WORDS    = 4,
  parameter logic [11:0] EXT0_DS_NEXT = 12'h140
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_ds,
  input  logic        pri_req,
  input  logic        pri_we,
  input  logic [9:0]  pri_addr,
  input  logic [3:0]  pri_be,
  input  logic [31:0] pri_wdata,
  input  logic        sb_req,
  input  logic        sb_we,
  input  logic [9:0]  sb_addr,
  input  logic [3:0]  sb_be,
  input  logic [31:0] sb_wdata,
  output logic        sb_rdy,
  output logic        rsp_vld,
  output logic        rsp_sb,
  output logic [31:0] rsp_data
);
  localparam int VIDX_W = (VND_WORDS > 1) ? $clog2(VND_WORDS) : 1;

  logic              rst_m_q, rst_s_n;
  logic              acc_vld, acc_we, acc_sb;
  dwaddr_t           acc_addr, win_dw;
  be_t               acc_be;
  word_t             acc_wdata, rdata;
  sel_e              req_sel, fwd_sel, eff_sel;
  logic [VIDX_W-1:0] req_vidx, fwd_vidx, eff_vidx;
  logic              rsp_vld_d, rsp_en;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  brcfg_arb u_arb (
    .pri_req(pri_req), .pri_we(pri_we), .pri_addr(pri_addr), .pri_be(pri_be),
    .pri_wdata(pri_wdata), .sb_req(sb_req), .sb_we(sb_we), .sb_addr(sb_addr),
    .sb_be(sb_be), .sb_wdata(sb_wdata), .sb_rdy(sb_rdy), .acc_vld(acc_vld),
    .acc_we(acc_we), .acc_sb(acc_sb), .acc_addr(acc_addr), .acc_be(acc_be),
    .acc_wdata(acc_wdata)
  );

  brcfg_decode #(.VND_WORDS(VND_WORDS), .VIDX_W(VIDX_W)) u_dec_req (
    .addr(acc_addr), .via_sb(acc_sb), .fwd(1'b0), .port_ds(port_ds),
    .sel(req_sel), .vidx(req_vidx)
  );

  brcfg_decode #(.VND_WORDS(VND_WORDS), .VIDX_W(VIDX_W)) u_dec_win (
    .addr(win_dw), .via_sb(1'b0), .fwd(1'b1), .port_ds(port_ds),
    .sel(fwd_sel), .vidx(fwd_vidx)
  );

  always_comb begin
    if (!acc_vld) begin
      eff_sel  = SEL_NONE;
      eff_vidx = req_vidx;
    end else if (req_sel == SEL_WDATA) begin
      eff_sel  = fwd_sel;
      eff_vidx = fwd_vidx;
    end else begin
      eff_sel  = req_sel;
      eff_vidx = req_vidx;
    end
  end

  brcfg_regs #(
    .ID_VALUE(ID_VALUE), .VND_WORDS(VND_WORDS), .VIDX_W(VIDX_W),
    .EXT0_DS_NEXT(EXT0_DS_NEXT)
  ) u_regs (
    .clk(clk), .rst_n(rst_s_n), .port_ds(port_ds), .acc_vld(acc_vld),
    .acc_we(acc_we), .acc_sb(acc_sb), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .sel(eff_sel), .vidx(eff_vidx), .rdata(rdata), .win_dw(win_dw)
  );

  assign rsp_vld_d = acc_vld & ~acc_we;
  assign rsp_en    = rsp_vld_d;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rsp_vld <= 1'b0;
    else          rsp_vld <= rsp_vld_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_data <= '0;
      rsp_sb   <= 1'b0;
    end else if (rsp_en) begin
      rsp_data <= rdata;
      rsp_sb   <= acc_sb;
    end
  end

  p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_vld && !acc_we) |=> rsp_vld);
  p_no_rsp_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(acc_vld && !acc_we) |=> !rsp_vld);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_vld && !acc_we && eff_sel == SEL_NONE) |=> (rsp_data == 32'h0));
  p_us_slot_hidden_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_vld && !acc_sb && !port_ds && (acc_addr == A_SLOTCAP || acc_addr == A_SLOTCTL))
      |-> (req_sel == SEL_NONE));
  p_sb_no_window_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_vld && acc_sb) |-> (req_sel != SEL_WADDR && req_sel != SEL_WDATA));
  p_pri_wins_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    pri_req |-> (!sb_rdy && !acc_sb));
  p_sb_taken_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sb_req && sb_rdy) |-> (acc_vld && acc_sb));
endmodule

// File: tb/bridge_cfg_space_tb.sv
`timescale 1ns/1ps
module bridge_cfg_space_tb_top;
  localparam logic [31:0] T_ID  = 32'h5A17_C0DE;
  localparam int          T_VND = 3;
  localparam logic [11:0] T_E0N = 12'h140;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, port_ds;
  logic        pri_req, pri_we, sb_req, sb_we;
  logic [9:0]  pri_addr, sb_addr;
  logic [3:0]  pri_be, sb_be;
  logic [31:0] pri_wdata, sb_wdata;
  logic        sb_rdy, rsp_vld, rsp_sb;
  logic [31:0] rsp_data;

  bridge_cfg_space #(.ID_VALUE(T_ID), .VND_WORDS(T_VND), .EXT0_DS_NEXT(T_E0N)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_ds(port_ds),
    .pri_req(pri_req), .pri_we(pri_we), .pri_addr(pri_addr), .pri_be(pri_be),
    .pri_wdata(pri_wdata), .sb_req(sb_req), .sb_we(sb_we), .sb_addr(sb_addr),
    .sb_be(sb_be), .sb_wdata(sb_wdata), .sb_rdy(sb_rdy), .rsp_vld(rsp_vld),
    .rsp_sb(rsp_sb), .rsp_data(rsp_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state, byte-addressed
  logic [31:0] m_scr, m_scap, m_sctl, m_e1r;
  logic [31:0] m_vnd [T_VND];
  logic [11:0] m_win, m_e0n, m_e1n;
  logic [7:0]  m_pn;
  bit          m_pp, m_e0p, m_e1p;

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_read(int a, bit sb, bit fwd);
    logic [11:0] e0;
    if (fwd && a < 'h100) return 32'h0;
    if (a >= 'h400 && a < 'h400 + 4*T_VND) return m_vnd[(a - 'h400) / 4];
    e0 = m_e0p ? m_e0n : (port_ds ? T_E0N : 12'h000);
    case (a)
      'h000: return T_ID;
      'h00C: return m_scr;
      'h034: return 32'h40;
      'h040: return {8'h00, (port_ds ? 4'h6 : 4'h5), 4'h2, (m_pp ? m_pn : 8'h00), 8'h10};
      'h054: return (port_ds || sb) ? m_scap : 32'h0;
      'h058: return (port_ds || sb) ? m_sctl : 32'h0;
      'h0F8: return sb ? 32'h0 : {20'h0, m_win};
      'h0FC: return sb ? 32'h0 : m_read(int'(m_win), 1'b0, 1'b1);
      'h100: return {e0, 4'h1, 16'h0001};
      'h140: return {(m_e1p ? m_e1n : 12'h000), 4'h1, 16'h000B};
      'h144: return m_e1r;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(int a, logic [3:0] be, logic [31:0] d, bit sb, bit fwd);
    logic [31:0] mg;
    if (fwd && a < 'h100) return;
    if (a == 'h0FC) begin
      if (!sb) m_write(int'(m_win), be, d, 1'b0, 1'b1);
      return;
    end
    mg = merge(m_read(a, sb, fwd), d, be);
    if (a >= 'h400 && a < 'h400 + 4*T_VND) begin
      m_vnd[(a - 'h400) / 4] = mg;
      return;
    end
    case (a)
      'h00C: m_scr = mg;
      'h054: if (port_ds || sb) m_scap = mg;
      'h058: if (port_ds || sb) m_sctl = mg;
      'h0F8: if (!sb) m_win = {mg[11:2], 2'b00};
      'h144: m_e1r = mg;
      'h040: if (sb && be[1]) begin m_pn = mg[15:8]; m_pp = 1; end
      'h100: if (sb && (be[2] | be[3])) begin m_e0n = mg[31:20]; m_e0p = 1; end
      'h140: if (sb && (be[2] | be[3])) begin m_e1n = mg[31:20]; m_e1p = 1; end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check ready, run model, compare response next negedge
  task automatic cyc(bit pr, bit pw, int pa, logic [3:0] pbe, logic [31:0] pd,
                     bit sr, bit sw, int sa, logic [3:0] sbe, logic [31:0] sd, string tag);
    bit ev = 0, esb = 0;
    logic [31:0] ed = 0;
    pri_req = pr; pri_we = pw; pri_addr = 10'(pa >> 2); pri_be = pbe; pri_wdata = pd;
    sb_req = sr; sb_we = sw; sb_addr = 10'(sa >> 2); sb_be = sbe; sb_wdata = sd;
    #1;
    chk(tag, "sb_rdy", {63'h0, sb_rdy}, {63'h0, !pr});
    if (pr) begin
      if (!pw) begin ev = 1; ed = m_read(pa, 1'b0, 1'b0); end
      else m_write(pa, pbe, pd, 1'b0, 1'b0);
    end else if (sr) begin
      if (!sw) begin ev = 1; esb = 1; ed = m_read(sa, 1'b1, 1'b0); end
      else m_write(sa, sbe, sd, 1'b1, 1'b0);
    end
    @(posedge clk);
    @(negedge clk);
    pri_req = 0; sb_req = 0;
    chk(tag, "response", {30'h0, rsp_vld, rsp_vld & rsp_sb, (rsp_vld ? rsp_data : 32'h0)},
        {30'h0, ev, esb, ed});
  endtask

  task automatic pwr(int a, logic [3:0] be, logic [31:0] d, string tag);
    cyc(1, 1, a, be, d, 0, 0, 0, 4'h0, 32'h0, tag);
  endtask
  task automatic prd(int a, string tag);
    cyc(1, 0, a, 4'hF, 32'h0, 0, 0, 0, 4'h0, 32'h0, tag);
  endtask
  task automatic swr(int a, logic [3:0] be, logic [31:0] d, string tag);
    cyc(0, 0, 0, 4'h0, 32'h0, 1, 1, a, be, d, tag);
  endtask
  task automatic srd(int a, string tag);
    cyc(0, 0, 0, 4'h0, 32'h0, 1, 0, a, 4'hF, 32'h0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; port_ds = 1;
    pri_req = 0; pri_we = 0; pri_addr = 0; pri_be = 0; pri_wdata = 0;
    sb_req = 0; sb_we = 0; sb_addr = 0; sb_be = 0; sb_wdata = 0;
    m_scr = 0; m_scap = 0; m_sctl = 0; m_e1r = 0; m_win = 0; m_e0n = 0; m_e1n = 0;
    m_pn = 0; m_pp = 0; m_e0p = 0; m_e1p = 0;
    for (int i = 0; i < T_VND; i++) m_vnd[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "reset rsp_vld", {63'h0, rsp_vld}, 64'h0);
    chk("R12", "reset sb_rdy", {63'h0, sb_rdy}, 64'h1);

    // R6 fixed values, R1 response timing
    prd('h000, "R6"); prd('h034, "R6"); prd('h040, "R6");
    // R4 byte enables
    pwr('h00C, 4'hF, 32'h1122_3344, "R4"); prd('h00C, "R4");
    pwr('h00C, 4'b0101, 32'hAABB_CCDD, "R4"); prd('h00C, "R4");
    pwr('h400, 4'b1001, 32'hDEAD_BEEF, "R4"); pwr('h408, 4'hF, 32'h0BAD_F00D, "R4");
    prd('h400, "R4"); prd('h404, "R4"); prd('h408, "R4");
    pwr('h144, 4'b1000, 32'h7700_0000, "R4"); prd('h144, "R4");
    // R2 reserved reads in each region
    prd('h004, "R2"); prd('h0F0, "R2"); prd('h104, "R2"); prd('h200, "R2");
    prd('h40C, "R2"); prd('hFFC, "R2");
    // R3 reserved writes change nothing
    pwr('h004, 4'hF, 32'hFFFF_FFFF, "R3"); pwr('h40C, 4'hF, 32'hFFFF_FFFF, "R3");
    pwr('h3FC, 4'hF, 32'hFFFF_FFFF, "R3");
    prd('h00C, "R3"); prd('h408, "R3"); prd('h40C, "R3"); prd('h144, "R3");
    // R5 slot registers hidden upstream for the primary path
    pwr('h054, 4'hF, 32'hC0FF_EE01, "R5"); pwr('h058, 4'hF, 32'h0000_00A5, "R5");
    prd('h054, "R5");
    port_ds = 0;
    prd('h054, "R5"); prd('h058, "R5");
    pwr('h054, 4'hF, 32'h1234_5678, "R5"); prd('h040, "R6");
    port_ds = 1;
    prd('h054, "R5"); prd('h058, "R5");
    // R9 side-band reaches slot registers in upstream mode
    port_ds = 0;
    swr('h058, 4'b0011, 32'h0000_BEEF, "R9"); srd('h058, "R9"); srd('h054, "R9");
    srd('h00C, "R9"); srd('h000, "R9"); srd('h404, "R9");
    port_ds = 1;
    prd('h058, "R9");
    // R7 window
    pwr('h0F8, 4'hF, 32'hFFFF_F147, "R7"); prd('h0F8, "R7");
    prd('h0FC, "R7"); pwr('h0FC, 4'b0011, 32'h0000_5A5A, "R7"); prd('h144, "R7");
    pwr('h0F8, 4'hF, 32'h0000_0408, "R7"); prd('h0FC, "R7");
    pwr('h0FC, 4'hF, 32'h600D_CAFE, "R7"); prd('h408, "R7");
    pwr('h0F8, 4'hF, 32'h0000_000C, "R7"); prd('h0FC, "R7");
    pwr('h0FC, 4'hF, 32'h0000_0000, "R7"); prd('h00C, "R7");
    pwr('h0F8, 4'hF, 32'h0000_0100, "R7"); prd('h0FC, "R10");
    // R8 side-band blocked from the window
    srd('h0F8, "R8"); srd('h0FC, "R8");
    swr('h0F8, 4'hF, 32'h0000_0144, "R8"); swr('h0FC, 4'hF, 32'hFFFF_FFFF, "R8");
    prd('h0F8, "R8"); prd('h100, "R8");
    // R10 default links by mode
    prd('h100, "R10"); prd('h140, "R10");
    port_ds = 0;
    prd('h100, "R10"); srd('h100, "R10");
    // R11 relinking only from side-band
    pwr('h100, 4'hF, 32'hFFFF_FFFF, "R11"); prd('h100, "R11");
    pwr('h040, 4'hF, 32'hFFFF_FFFF, "R11"); prd('h040, "R11");
    swr('h100, 4'b1100, 32'h1800_0000, "R11"); prd('h100, "R11");
    port_ds = 1;
    prd('h100, "R11");
    swr('h040, 4'b0010, 32'h0000_5000, "R11"); prd('h040, "R11");
    swr('h040, 4'b0001, 32'h0000_00FF, "R11"); prd('h040, "R11");
    swr('h140, 4'b1000, 32'hAB00_0000, "R11"); prd('h140, "R11");
    // R12 collisions
    cyc(1, 0, 'h00C, 4'hF, 32'h0, 1, 1, 'h00C, 4'hF, 32'h9999_9999, "R12");
    prd('h00C, "R12");
    cyc(1, 1, 'h00C, 4'hF, 32'h2468_ACE0, 1, 0, 'h000, 4'hF, 32'h0, "R12");
    swr('h00C, 4'hF, 32'h9999_9999, "R12");
    cyc(1, 0, 'h00C, 4'hF, 32'h0, 1, 0, 'h000, 4'hF, 32'h0, "R12");
    cyc(0, 0, 0, 4'h0, 32'h0, 0, 0, 0, 4'h0, 32'h0, "R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule